// File: doc/BRIEF.md
# Mixed-Size Instruction TLB with Overlap Machine Check

This block is a small fully associative translation cache for the code-fetch path. It holds linear-to-physical translations of four page sizes. Fetch lookups are answered one cycle after the request with a hit flag, a physical address and a memory type. Translations are installed from a page-walk response port. A fill carries both the guest and the second-stage page size, and the entry records the smaller of the two.

Software may remap a linear address from a small page to a larger one without first invalidating the old translation. Both entries then stay live, and they can disagree on the physical address or the memory type. A fetch that lands on such an overlap does not return either answer. It raises a machine-check pulse and latches a fixed error code until software clears it. An invalidate-by-address command removes every entry that covers the given address, so the overlap goes away. A flush-all command empties the cache in one cycle.

Top module: `itlb_sizeguard`

## Requirements
- R1: A lookup with `lk_valid` high gives `rsp_valid` high in the next cycle. On a hit, `rsp_pa` takes the physical address bits at and above the entry's page offset from the entry, and the lower bits from the linear address. `rsp_mtype` is the entry's memory type.
- R2: On a miss, `rsp_hit`, `rsp_pa` and `rsp_mtype` are zero in the response cycle. Without a request, `rsp_valid`, `rsp_hit` and `mc_pulse` stay low.
- R3: Size codes are 0 = 4 KB, 1 = 2 MB, 2 = 4 MB and 3 = 1 GB, with page offsets of 12, 21, 22 and 30 bits. A fill records the smaller of `fill_gsize` and `fill_nsize`.
- R4: A lookup compares only the linear address bits above the entry's page offset.
- R5: `flush_all` clears every entry in one cycle. A fill in the same cycle is still installed.
- R6: An invalidate clears every entry whose page covers `inv_la`, and it leaves all other entries in place.
- R7: Sometimes two or more live entries cover the fetch address and give it different physical addresses or memory types. The response cycle then shows `mc_pulse` high and `rsp_hit` low. Overlapping entries that agree give a normal hit.
- R8: Each machine check sets `mc_pending`, and `mc_code` then reads 0x150. Both hold until `mc_clear` is pulsed. A new machine check in the same cycle as `mc_clear` wins over the clear.
- R9: An invalidate of the address between a conflicting fill and the next fetch removes the conflict. That fetch then gives no machine check.
- R10: A fill goes to a choice of entry in this order: first, a live entry with the same size and the same page base, which is overwritten in place; second, the lowest-numbered invalid entry; third, a round-robin victim that starts at entry 0.
- R11: A lookup in the same cycle as a fill, an invalidate or a flush sees the contents from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Fetch lookup request |
| lk_la | input | LA_W | Fetch linear address |
| fill_valid | input | 1 | Page-walk fill strobe |
| fill_la | input | LA_W | Linear address of the fill |
| fill_pa | input | PA_W | Physical address for `fill_la` |
| fill_mtype | input | MT_W | Memory type of the fill |
| fill_gsize | input | 2 | Guest page size code |
| fill_nsize | input | 2 | Second-stage page size code |
| inv_valid | input | 1 | Invalidate-by-address strobe |
| inv_la | input | LA_W | Address to invalidate |
| flush_all | input | 1 | Clear all entries |
| mc_clear | input | 1 | Clear the latched machine-check code |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Unambiguous hit |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_mtype | output | MT_W | Memory type of the hit |
| mc_pulse | output | 1 | One-cycle machine-check signal |
| mc_pending | output | 1 | Machine check latched |
| mc_code | output | 16 | Latched error code, 0 when none |

## Verification
A fetch lookup and an array update (a fill, or a flush combined with a fill) can land on the same clock edge. The bench drives both strobes in one cycle. It then expects the lookup to miss, and it expects a lookup in the following cycle to hit on the new entry. A machine-check event and `mc_clear` can also coincide. This is provoked by refetching a conflicting address while the clear is held, and `mc_pending` must remain set afterwards.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_4M = 2'd2,
    PG_1G = 2'd3
  } pg_size_e;

  localparam int unsigned BASE_SHIFT = 12;
  localparam logic [15:0] MC_SIZE_CONFLICT = 16'h0150;

  function automatic int unsigned pg_shift(input pg_size_e s);
    case (s)
      PG_2M:   return 21;
      PG_4M:   return 22;
      PG_1G:   return 30;
      default: return 12;
    endcase
  endfunction

  function automatic pg_size_e pg_min(input pg_size_e a, input pg_size_e b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/itlb_match.sv
module itlb_match
  import itlb_pkg::*;
#(
  parameter int unsigned LA_W = 32
) (
  input  logic                       ent_valid,
  input  logic [1:0]                 ent_size,
  input  logic [LA_W-1:BASE_SHIFT]   ent_vpn,
  input  logic [LA_W-1:BASE_SHIFT]   probe_vpn,
  output logic                       hit
);
  localparam int unsigned VW = LA_W - BASE_SHIFT;

  logic [VW-1:0] keep;
  int unsigned   drop;

  always_comb begin
    drop = pg_shift(pg_size_e'(ent_size)) - BASE_SHIFT;
    keep = {VW{1'b1}} << drop;
    hit  = ent_valid && (((probe_vpn ^ ent_vpn) & keep) == '0);
  end
endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
  import itlb_pkg::*;
#(
  parameter int unsigned LA_W = 32,
  parameter int unsigned PA_W = 32
) (
  input  logic [1:0]               ent_size,
  input  logic [PA_W-1:BASE_SHIFT] ent_pfn,
  input  logic [LA_W-1:0]          probe_la,
  output logic [PA_W-1:0]          tr_pa
);
  localparam int unsigned PW = PA_W - BASE_SHIFT;

  logic [PW-1:0] keep;
  logic [PW-1:0] probe_hi;
  int unsigned   drop;

  always_comb begin
    drop     = pg_shift(pg_size_e'(ent_size)) - BASE_SHIFT;
    keep     = {PW{1'b1}} << drop;
    probe_hi = PW'(probe_la[LA_W-1:BASE_SHIFT]);
    tr_pa    = {(ent_pfn & keep) | (probe_hi & ~keep), probe_la[BASE_SHIFT-1:0]};
  end
endmodule

// File: rtl/itlb_victim.sv
module itlb_victim #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [ENTRIES-1:0] ent_same,
  input  logic               take,
  output logic [IDX_W-1:0]   way
);
  logic [IDX_W-1:0] rr_q, rr_d, free_idx, same_idx;
  logic             have_free, have_same, use_rr;

  always_comb begin
    have_free = 1'b0;
    have_same = 1'b0;
    free_idx  = '0;
    same_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
      if (ent_same[i]) begin
        have_same = 1'b1;
        same_idx  = IDX_W'(i);
      end
    end
    if (have_same)      way = same_idx;
    else if (have_free) way = free_idx;
    else                way = rr_q;
    use_rr = take && !have_same && !have_free;
    rr_d   = rr_q;
    if (use_rr) rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/itlb_sizeguard.sv
module itlb_sizeguard
  import itlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned LA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned MT_W    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [LA_W-1:0] lk_la,
  input  logic            fill_valid,
  input  logic [LA_W-1:0] fill_la,
  input  logic [PA_W-1:0] fill_pa,
  input  logic [MT_W-1:0] fill_mtype,
  input  logic [1:0]      fill_gsize,
  input  logic [1:0]      fill_nsize,
  input  logic            inv_valid,
  input  logic [LA_W-1:0] inv_la,
  input  logic            flush_all,
  input  logic            mc_clear,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [PA_W-1:0] rsp_pa,
  output logic [MT_W-1:0] rsp_mtype,
  output logic            mc_pulse,
  output logic            mc_pending,
  output logic [15:0]     mc_code
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry array
  logic [ENTRIES-1:0]        v_q, v_d;
  logic [1:0]                size_q [ENTRIES];
  logic [LA_W-1:BASE_SHIFT]  vpn_q  [ENTRIES];
  logic [PA_W-1:BASE_SHIFT]  pfn_q  [ENTRIES];
  logic [MT_W-1:0]           mt_q   [ENTRIES];

  logic [ENTRIES-1:0] lk_hit, inv_hit, fill_hit, fill_same;
  logic [PA_W-1:0]    lk_pa [ENTRIES];
  logic [1:0]         fill_sz;
  logic [IDX_W-1:0]   fill_way;

  logic unused_ok;
  assign unused_ok = ^{fill_pa[BASE_SHIFT-1:0], fill_la[BASE_SHIFT-1:0], inv_la[BASE_SHIFT-1:0]};

  assign fill_sz = pg_min(pg_size_e'(fill_gsize), pg_size_e'(fill_nsize));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    itlb_match #(.LA_W(LA_W)) u_lk_match (
      .ent_valid(v_q[g]), .ent_size(size_q[g]), .ent_vpn(vpn_q[g]),
      .probe_vpn(lk_la[LA_W-1:BASE_SHIFT]), .hit(lk_hit[g]));
    itlb_match #(.LA_W(LA_W)) u_inv_match (
      .ent_valid(v_q[g]), .ent_size(size_q[g]), .ent_vpn(vpn_q[g]),
      .probe_vpn(inv_la[LA_W-1:BASE_SHIFT]), .hit(inv_hit[g]));
    itlb_match #(.LA_W(LA_W)) u_fill_match (
      .ent_valid(v_q[g]), .ent_size(size_q[g]), .ent_vpn(vpn_q[g]),
      .probe_vpn(fill_la[LA_W-1:BASE_SHIFT]), .hit(fill_hit[g]));
    itlb_xlate #(.LA_W(LA_W), .PA_W(PA_W)) u_xlate (
      .ent_size(size_q[g]), .ent_pfn(pfn_q[g]), .probe_la(lk_la), .tr_pa(lk_pa[g]));
    assign fill_same[g] = fill_hit[g] && (size_q[g] == fill_sz);
  end

  itlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .ent_valid(v_q), .ent_same(fill_same),
    .take(fill_valid), .way(fill_way));

  // valid next state: flush or invalidate first, fill on top
  always_comb begin
    v_d = v_q;
    if (flush_all)      v_d = '0;
    else if (inv_valid) v_d = v_q & ~inv_hit;
    if (fill_valid)     v_d[fill_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_valid && (fill_way == IDX_W'(i))) begin
        size_q[i] <= fill_sz;
        vpn_q[i]  <= fill_la[LA_W-1:BASE_SHIFT];
        pfn_q[i]  <= fill_pa[PA_W-1:BASE_SHIFT];
        mt_q[i]   <= fill_mtype;
      end
    end
  end

  // lookup: select lowest hit, flag any disagreeing hit
  logic [PA_W-1:0] sel_pa;
  logic [MT_W-1:0] sel_mt;
  logic            any_hit, clash;

  always_comb begin
    sel_pa = '0;
    sel_mt = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_hit[i]) begin
        sel_pa = lk_pa[i];
        sel_mt = mt_q[i];
      end
    end
    any_hit = |lk_hit;
    clash   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit[i] && ((lk_pa[i] != sel_pa) || (mt_q[i] != sel_mt))) clash = 1'b1;
    end
  end

  logic            good_d, mc_d, pend_d;
  logic            rsp_valid_q, rsp_hit_q, mc_pulse_q, pend_q;
  logic [PA_W-1:0] rsp_pa_q, rsp_pa_d;
  logic [MT_W-1:0] rsp_mt_q, rsp_mt_d;

  always_comb begin
    good_d   = lk_valid && any_hit && !clash;
    mc_d     = lk_valid && clash;
    rsp_pa_d = good_d ? sel_pa : '0;
    rsp_mt_d = good_d ? sel_mt : '0;
    if (mc_d)          pend_d = 1'b1;
    else if (mc_clear) pend_d = 1'b0;
    else               pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      mc_pulse_q  <= 1'b0;
      pend_q      <= 1'b0;
      rsp_pa_q    <= '0;
      rsp_mt_q    <= '0;
    end else begin
      rsp_valid_q <= lk_valid;
      rsp_hit_q   <= good_d;
      mc_pulse_q  <= mc_d;
      pend_q      <= pend_d;
      if (lk_valid) begin
        rsp_pa_q <= rsp_pa_d;
        rsp_mt_q <= rsp_mt_d;
      end
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_pa     = rsp_pa_q;
  assign rsp_mtype  = rsp_mt_q;
  assign mc_pulse   = mc_pulse_q;
  assign mc_pending = pend_q;
  assign mc_code    = pend_q ? MC_SIZE_CONFLICT : 16'h0000;
endmodule

// File: rtl/itlb_sizeguard_chk.sv
module itlb_sizeguard_chk (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic fill_valid,
  input logic flush_all,
  input logic mc_clear,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic mc_pulse,
  input logic mc_pending
);
  a_r1_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r2_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit && !mc_pulse));

  a_r5_flush_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_valid) ##1 lk_valid |=> !rsp_hit);

  a_r7_mc_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
    mc_pulse |-> (rsp_valid && !rsp_hit));

  a_r8_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_pending && !mc_clear) |=> mc_pending);

  a_r8_pending_rise_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_pending) |-> mc_pulse);
endmodule

bind itlb_sizeguard itlb_sizeguard_chk i_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .fill_valid(fill_valid),
  .flush_all(flush_all), .mc_clear(mc_clear), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .mc_pulse(mc_pulse), .mc_pending(mc_pending));

// File: tb/test_itlb_sizeguard.sv
module test_itlb_sizeguard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, fill_valid, inv_valid, flush_all, mc_clear;
  logic [31:0] lk_la, fill_la, fill_pa, inv_la;
  logic [2:0]  fill_mtype;
  logic [1:0]  fill_gsize, fill_nsize;
  logic        rsp_valid, rsp_hit, mc_pulse, mc_pending;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_mtype;
  logic [15:0] mc_code;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  itlb_sizeguard i_itlb_sizeguard (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_la(lk_la),
    .fill_valid(fill_valid), .fill_la(fill_la), .fill_pa(fill_pa),
    .fill_mtype(fill_mtype), .fill_gsize(fill_gsize), .fill_nsize(fill_nsize),
    .inv_valid(inv_valid), .inv_la(inv_la), .flush_all(flush_all),
    .mc_clear(mc_clear), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_pa(rsp_pa), .rsp_mtype(rsp_mtype), .mc_pulse(mc_pulse),
    .mc_pending(mc_pending), .mc_code(mc_code));

  typedef struct packed {
    logic [1:0]  op;    // 0 fill, 1 lookup, 2 invalidate
    logic [31:0] la;
    logic [31:0] pa;
    logic [2:0]  mt;
    logic [1:0]  gs;
    logic [1:0]  ns;
    logic        eh;
    logic [31:0] epa;
    logic [2:0]  emt;
    logic        emc;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VT [NV] = '{
    '{2'd0, 32'h0040_1000, 32'h0009_3000, 3'd6, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b0}, // 4K fill
    '{2'd1, 32'h0040_1abc, 32'h0, 3'd0, 2'd0, 2'd0, 1'b1, 32'h0009_3abc, 3'd6, 1'b0}, // R1
    '{2'd1, 32'h0040_2abc, 32'h0, 3'd0, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b0},         // R2 R4
    '{2'd0, 32'h8000_0000, 32'h4000_0000, 3'd1, 2'd3, 2'd3, 1'b0, 32'h0, 3'd0, 1'b0}, // 1G fill
    '{2'd1, 32'hBFFF_FFF0, 32'h0, 3'd0, 2'd0, 2'd0, 1'b1, 32'h7FFF_FFF0, 3'd1, 1'b0}, // R4
    '{2'd1, 32'hC000_0000, 32'h0, 3'd0, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b0},         // R4
    '{2'd0, 32'h0123_4567, 32'h0AB5_4567, 3'd2, 2'd1, 2'd0, 1'b0, 32'h0, 3'd0, 1'b0}, // R3 min->4K
    '{2'd1, 32'h0123_4000, 32'h0, 3'd0, 2'd0, 2'd0, 1'b1, 32'h0AB5_4000, 3'd2, 1'b0}, // R3
    '{2'd1, 32'h0123_5000, 32'h0, 3'd0, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b0},         // R3
    '{2'd0, 32'h0060_0000, 32'h0180_0000, 3'd0, 2'd1, 2'd3, 1'b0, 32'h0, 3'd0, 1'b0}, // R3 min->2M
    '{2'd1, 32'h007F_FFFC, 32'h0, 3'd0, 2'd0, 2'd0, 1'b1, 32'h019F_FFFC, 3'd0, 1'b0}, // R3
    '{2'd2, 32'h0070_0000, 32'h0, 3'd0, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b0},         // R6
    '{2'd1, 32'h0060_0010, 32'h0, 3'd0, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b0},         // R6
    '{2'd1, 32'h0040_1004, 32'h0, 3'd0, 2'd0, 2'd0, 1'b1, 32'h0009_3004, 3'd6, 1'b0}, // R6 kept
    '{2'd0, 32'h0040_0000, 32'h0200_0000, 3'd6, 2'd1, 2'd1, 1'b0, 32'h0, 3'd0, 1'b0}, // 2M over 4K
    '{2'd1, 32'h0040_1004, 32'h0, 3'd0, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b1},         // R7
    '{2'd1, 32'h0040_5008, 32'h0, 3'd0, 2'd0, 2'd0, 1'b1, 32'h0200_5008, 3'd6, 1'b0}, // R7
    '{2'd2, 32'h0040_1000, 32'h0, 3'd0, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b0},         // R9
    '{2'd1, 32'h0040_1004, 32'h0, 3'd0, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b0},         // R9
    '{2'd0, 32'h0040_1000, 32'h0200_1000, 3'd6, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b0},
    '{2'd0, 32'h0040_0000, 32'h0200_0000, 3'd6, 2'd1, 2'd1, 1'b0, 32'h0, 3'd0, 1'b0},
    '{2'd1, 32'h0040_1ffc, 32'h0, 3'd0, 2'd0, 2'd0, 1'b1, 32'h0200_1ffc, 3'd6, 1'b0}, // R7 agree
    '{2'd0, 32'h0040_0000, 32'h0200_0000, 3'd5, 2'd1, 2'd1, 1'b0, 32'h0, 3'd0, 1'b0}, // R10 in place
    '{2'd1, 32'h0040_1000, 32'h0, 3'd0, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b1},         // R7 mtype
    '{2'd1, 32'h0040_3000, 32'h0, 3'd0, 2'd0, 2'd0, 1'b1, 32'h0200_3000, 3'd5, 1'b0}, // R10
    '{2'd0, 32'h0C00_0000, 32'h1000_0000, 3'd3, 2'd2, 2'd2, 1'b0, 32'h0, 3'd0, 1'b0}, // 4M fill
    '{2'd1, 32'h0C3F_FFF0, 32'h0, 3'd0, 2'd0, 2'd0, 1'b1, 32'h103F_FFF0, 3'd3, 1'b0}, // R4
    '{2'd1, 32'h0C40_0000, 32'h0, 3'd0, 2'd0, 2'd0, 1'b0, 32'h0, 3'd0, 1'b0}          // R4
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; fill_valid = 0; inv_valid = 0; flush_all = 0; mc_clear = 0;
  endtask

  task automatic do_fill(input logic [31:0] la, pa, input logic [2:0] mt, input logic [1:0] gs, ns);
    @(negedge clk);
    fill_valid = 1; fill_la = la; fill_pa = pa; fill_mtype = mt; fill_gsize = gs; fill_nsize = ns;
    @(negedge clk);
    idle();
  endtask

  task automatic do_inv(input logic [31:0] la);
    @(negedge clk);
    inv_valid = 1; inv_la = la;
    @(negedge clk);
    idle();
  endtask

  // response sampled one cycle after the request, at the falling edge
  task automatic do_look(input logic [31:0] la);
    @(negedge clk);
    lk_valid = 1; lk_la = la;
    @(negedge clk);
    idle();
  endtask

  task automatic chk_look(input string tag, input logic eh, input logic [31:0] epa,
                          input logic [2:0] emt, input logic emc);
    logic [37:0] a, e;
    a = {rsp_valid, rsp_hit, rsp_pa, rsp_mtype, mc_pulse};
    e = {1'b1, eh, epa, emt, emc};
    chk(a == e, tag, 64'(a), 64'(e));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle();
    lk_la = 0; fill_la = 0; fill_pa = 0; inv_la = 0; fill_mtype = 0; fill_gsize = 0; fill_nsize = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R2, R8)
    chk({rsp_valid, rsp_hit, mc_pulse, mc_pending, mc_code} == 20'h0, "R2 R8 reset",
        64'({rsp_valid, rsp_hit, mc_pulse, mc_pending, mc_code}), 64'h0);

    for (int k = 0; k < NV; k++) begin
      case (VT[k].op)
        2'd0: do_fill(VT[k].la, VT[k].pa, VT[k].mt, VT[k].gs, VT[k].ns);
        2'd2: do_inv(VT[k].la);
        default: begin
          do_look(VT[k].la);
          chk_look($sformatf("table row %0d (R1-R10 per row comment)", k),
                   VT[k].eh, VT[k].epa, VT[k].emt, VT[k].emc);
        end
      endcase
    end

    // R8: code latched, then cleared
    chk(mc_pending && mc_code == 16'h0150, "R8 latched code", 64'({mc_pending, mc_code}), 64'h1_0150);
    @(negedge clk); mc_clear = 1;
    @(negedge clk); idle();
    chk(!mc_pending && mc_code == 16'h0, "R8 cleared", 64'({mc_pending, mc_code}), 64'h0);

    // R8: new machine check beats clear in the same cycle
    @(negedge clk); lk_valid = 1; lk_la = 32'h0040_1000; mc_clear = 1;
    @(negedge clk); idle();
    chk(mc_pulse && mc_pending && mc_code == 16'h0150, "R8 set wins over clear",
        64'({mc_pulse, mc_pending, mc_code}), 64'h3_0150);
    @(negedge clk); mc_clear = 1;
    @(negedge clk); idle();

    // R11: lookup in the same cycle as a fill sees old contents
    @(negedge clk);
    lk_valid = 1; lk_la = 32'h0300_0000;
    fill_valid = 1; fill_la = 32'h0300_0000; fill_pa = 32'h0000_3000; fill_mtype = 3'd1;
    fill_gsize = 2'd0; fill_nsize = 2'd0;
    @(negedge clk); idle();
    chk_look("R11 same-cycle fill misses", 1'b0, 32'h0, 3'd0, 1'b0);
    do_look(32'h0300_0000);
    chk_look("R11 next lookup hits", 1'b1, 32'h0000_3000, 3'd1, 1'b0);

    // R5: flush and fill together
    @(negedge clk);
    flush_all = 1; fill_valid = 1; fill_la = 32'h0366_6000; fill_pa = 32'h0000_7000;
    fill_mtype = 3'd2; fill_gsize = 2'd0; fill_nsize = 2'd0;
    @(negedge clk); idle();
    do_look(32'h0366_6123);
    chk_look("R5 fill survives flush", 1'b1, 32'h0000_7123, 3'd2, 1'b0);
    do_look(32'h0C00_0000);
    chk_look("R5 flushed entry gone", 1'b0, 32'h0, 3'd0, 1'b0);

    // R10: round-robin replacement once all entries are valid
    for (int k = 0; k < 9; k++)
      do_fill(32'h1000_0000 + 32'(k) * 32'h1000, 32'h2000_0000 + 32'(k) * 32'h1000, 3'd4, 2'd0, 2'd0);
    do_look(32'h1000_0000);
    chk_look("R10 first victim evicted", 1'b0, 32'h0, 3'd0, 1'b0);
    do_look(32'h1000_1000);
    chk_look("R10 second victim evicted", 1'b0, 32'h0, 3'd0, 1'b0);
    do_look(32'h1000_2010);
    chk_look("R10 survivor kept", 1'b1, 32'h2000_2010, 3'd4, 1'b0);
    do_look(32'h1000_8000);
    chk_look("R10 newest present", 1'b1, 32'h2000_8000, 3'd4, 1'b0);
    do_look(32'h0366_6000);
    chk_look("R10 older entry kept", 1'b1, 32'h0000_7000, 3'd2, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule